// File: doc/BRIEF.md
# Guard-Before-Trip Supervisor

This block decides when a teleprotection receiver may pass trip commands on to its output stage. The trip path stays closed until a clean guard tone has been received without a break for a programmable number of milliseconds. While guard is present, the path stays open. When guard disappears, the path stays open for a programmable grace window so that a trip can arrive. If the window ends with no trip and no returning guard, the path closes. It reopens only after guard comes back and the full qualification interval has run again.

A trip that reaches the block while the path is open switches supervision off. The path is then held open with no time limit, so that a sustained trip can keep a breaker open. Supervision is switched back on only after guard has been received without interruption for a fixed re-arm period, 100 ms by default. All timing is counted on a one-clock millisecond tick. The guard, trip and noise inputs are already qualified by upstream pickup logic.

Top module: `gbt_supervisor`

## Requirements
- R1: After reset, `tripEnable` and `defeated` are both 0.
- R2: When the path is closed and qualifying, `tripEnable` goes high right after the clock edge that samples the `armTimeMs`-th `msTick` of continuous clean guard (`guardIn`=1 and `noiseIn`=0). A setting of 0 acts as 1.
- R3: While qualifying, a cycle with `noiseIn`=1 or `guardIn`=0 sets the qualification count back to zero.
- R4: When guard is lost while the path is open (and supervision is active), `tripEnable` stays high for `windowMs` ticks. It drops right after the edge that samples the `windowMs`-th tick, if no trip and no guard arrived in that time. `tripEnable` never falls on a cycle without a tick.
- R5: If guard returns during the window, the path stays open and the window count is discarded. A later loss of guard starts a full new window.
- R6: After the window has expired, `tripEnable` stays low until guard reappears. A full qualification interval is then required, counted from the cycle after guard reappears.
- R7: `tripIn`=1 while `tripEnable` is high sets `defeated` to 1 on the next edge, and `tripEnable` stays high.
- R8: `tripIn` has no effect while `tripEnable` is low: `defeated` stays 0.
- R9: While `defeated` is 1, `tripEnable` stays high however long guard is absent.
- R10: `defeated` clears, with `tripEnable` still high, right after the edge that samples the `REARM_MS`-th tick of uninterrupted guard.
- R11: A cycle with `guardIn`=0 during the re-arm count sets that count back to zero.
- R12: `tripEnable` is low only while qualifying or after the window has expired. `defeated` is high only while supervision is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse once per millisecond |
| guardIn | input | 1 | Qualified guard present |
| tripIn | input | 1 | Qualified trip present |
| noiseIn | input | 1 | Noise seen on the channel |
| armTimeMs | input | CNT_W | Clean-guard qualification interval in ticks |
| windowMs | input | CNT_W | Grace window after guard loss, in ticks |
| tripEnable | output | 1 | Trip path open |
| defeated | output | 1 | Supervision switched off by a trip |

## Verification
The hardest state to reach is the end of the re-arm count. It needs a hundred ticks of unbroken guard after a trip has switched supervision off, and random stimulus rarely produces that. The bench drives guard in long random runs, up to several hundred cycles, with frequent ticks, so that re-arming happens many times. Directed sequences place a single guard gap at the 51st tick of a re-arm count, test a zero qualification setting, and return guard in the middle of a window. They then check the exact edge on which each output changes.

// File: rtl/gbt_pkg.sv
package gbt_pkg;

  typedef enum logic [2:0] {
    ST_ARMING,
    ST_ARMED,
    ST_WINDOW,
    ST_BLOCKED,
    ST_DEFEATED
  } supState_e;

  typedef enum logic [1:0] {
    LIM_ARM,
    LIM_WIN,
    LIM_REARM
  } limSel_e;

  // strobes from control to the interval counter
  typedef struct packed {
    logic    clr;
    logic    inc;
    limSel_e sel;
  } cntCmd_t;

endpackage

// File: rtl/gbt_timer.sv
module gbt_timer
  import gbt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int REARM_MS = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] armTimeMs,
  input  logic [CNT_W-1:0] windowMs,
  output logic             limitHit
);

  localparam int CMP_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] REARM_LIM = CNT_W'(REARM_MS);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  logic [CMP_W-1:0] nextCount;

  always_comb begin
    unique case (cmd.sel)
      LIM_ARM:   limit = armTimeMs;
      LIM_WIN:   limit = windowMs;
      LIM_REARM: limit = REARM_LIM;
      default:   limit = REARM_LIM;
    endcase
  end

  assign nextCount = {1'b0, count} + CMP_W'(1);
  // a zero limit is reached on the first counted tick
  assign limitHit  = cmd.inc && (nextCount >= {1'b0, limit});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (cmd.clr) begin
      count <= '0;
    end else if (cmd.inc && (count != CNT_MAX)) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/gbt_fsm.sv
module gbt_fsm
  import gbt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    msTick,
  input  logic    guardIn,
  input  logic    tripIn,
  input  logic    noiseIn,
  input  logic    limitHit,
  output cntCmd_t cmd,
  output logic    tripEnable,
  output logic    defeated
);

  supState_e state, stateNext;

  always_comb begin
    stateNext = state;
    cmd.clr   = 1'b0;
    cmd.inc   = 1'b0;
    cmd.sel   = LIM_ARM;
    unique case (state)
      ST_ARMING: begin
        cmd.sel = LIM_ARM;
        if (guardIn && !noiseIn) begin
          cmd.inc = msTick;
          if (limitHit) begin
            stateNext = ST_ARMED;
            cmd.clr   = 1'b1;
          end
        end else begin
          cmd.clr = 1'b1;
        end
      end
      ST_ARMED: begin
        cmd.clr = 1'b1;
        if (tripIn)        stateNext = ST_DEFEATED;
        else if (!guardIn) stateNext = ST_WINDOW;
      end
      ST_WINDOW: begin
        cmd.sel = LIM_WIN;
        if (tripIn) begin
          stateNext = ST_DEFEATED;
          cmd.clr   = 1'b1;
        end else if (guardIn) begin
          stateNext = ST_ARMED;
          cmd.clr   = 1'b1;
        end else begin
          cmd.inc = msTick;
          if (limitHit) begin
            stateNext = ST_BLOCKED;
            cmd.clr   = 1'b1;
          end
        end
      end
      ST_BLOCKED: begin
        cmd.clr = 1'b1;
        if (guardIn) stateNext = ST_ARMING;
      end
      ST_DEFEATED: begin
        cmd.sel = LIM_REARM;
        if (guardIn) begin
          cmd.inc = msTick;
          if (limitHit) begin
            stateNext = ST_ARMED;
            cmd.clr   = 1'b1;
          end
        end else begin
          cmd.clr = 1'b1;
        end
      end
      default: begin
        stateNext = ST_ARMING;
        cmd.clr   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ARMING;
    else       state <= stateNext;
  end

  assign tripEnable = (state == ST_ARMED) || (state == ST_WINDOW) || (state == ST_DEFEATED);
  assign defeated   = (state == ST_DEFEATED);

  // R7: a trip on an open path switches supervision off
  assert_trip_defeats_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tripEnable && tripIn && !defeated) |=> (defeated && tripEnable));

  // R8: a closed path cannot be defeated
  assert_closed_no_defeat_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!tripEnable) |=> !defeated);

  // R9: defeated keeps the path open
  assert_defeat_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    defeated |=> tripEnable);

  // R10: no exit from defeated without guard
  assert_rearm_needs_guard_R10: assert property (@(posedge clk) disable iff (!rstN)
    (defeated && !guardIn) |=> defeated);

  // R2: the path only opens on clean guard
  assert_open_needs_guard_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tripEnable) |-> $past(guardIn && !noiseIn && msTick));

  // R4: the window closes only on a tick
  assert_close_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tripEnable && !msTick) |=> tripEnable);

  // R12: defeated implies an open path
  assert_flags_consistent_R12: assert property (@(posedge clk) disable iff (!rstN)
    defeated |-> tripEnable);

endmodule

// File: rtl/gbt_supervisor.sv
module gbt_supervisor
  import gbt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int REARM_MS = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             guardIn,
  input  logic             tripIn,
  input  logic             noiseIn,
  input  logic [CNT_W-1:0] armTimeMs,
  input  logic [CNT_W-1:0] windowMs,
  output logic             tripEnable,
  output logic             defeated
);

  cntCmd_t cntCmd;
  logic    limitHit;

  gbt_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .msTick    (msTick),
    .guardIn   (guardIn),
    .tripIn    (tripIn),
    .noiseIn   (noiseIn),
    .limitHit  (limitHit),
    .cmd       (cntCmd),
    .tripEnable(tripEnable),
    .defeated  (defeated)
  );

  gbt_timer #(
    .CNT_W   (CNT_W),
    .REARM_MS(REARM_MS)
  ) u_timer (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cntCmd),
    .armTimeMs(armTimeMs),
    .windowMs (windowMs),
    .limitHit (limitHit)
  );

endmodule

// File: tb/gbt_supervisor_tb.sv
module gbt_supervisor_tb;

  localparam int CNT_W    = 16;
  localparam int REARM_MS = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, guardIn = 1'b0, tripIn = 1'b0, noiseIn = 1'b0;
  logic [CNT_W-1:0] armTimeMs = 16'd3;
  logic [CNT_W-1:0] windowMs  = 16'd4;
  logic tripEnable, defeated;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  gbt_supervisor #(.CNT_W(CNT_W), .REARM_MS(REARM_MS)) u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .guardIn(guardIn),
    .tripIn(tripIn), .noiseIn(noiseIn), .armTimeMs(armTimeMs),
    .windowMs(windowMs), .tripEnable(tripEnable), .defeated(defeated)
  );

  // behavioural expectation built from the requirements
  localparam int M_ARMING = 0, M_ARMED = 1, M_WINDOW = 2, M_BLOCKED = 3, M_DEF = 4;
  int mState = M_ARMING;
  int mCnt   = 0;

  function automatic bit reached(int cnt, int lim);
    return (cnt + 1) >= lim;
  endfunction

  function automatic logic expEnable(int st);
    return (st == M_ARMED) || (st == M_WINDOW) || (st == M_DEF);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState <= M_ARMING; mCnt <= 0;
    end else begin
      case (mState)
        M_ARMING:
          if (guardIn && !noiseIn) begin
            if (msTick) begin
              if (reached(mCnt, int'(armTimeMs))) begin mState <= M_ARMED; mCnt <= 0; end
              else mCnt <= mCnt + 1;
            end
          end else mCnt <= 0;
        M_ARMED:
          if (tripIn) mState <= M_DEF;
          else if (!guardIn) mState <= M_WINDOW;
        M_WINDOW:
          if (tripIn) begin mState <= M_DEF; mCnt <= 0; end
          else if (guardIn) begin mState <= M_ARMED; mCnt <= 0; end
          else if (msTick) begin
            if (reached(mCnt, int'(windowMs))) begin mState <= M_BLOCKED; mCnt <= 0; end
            else mCnt <= mCnt + 1;
          end
        M_BLOCKED:
          if (guardIn) mState <= M_ARMING;
        default:
          if (guardIn) begin
            if (msTick) begin
              if (reached(mCnt, REARM_MS)) begin mState <= M_ARMED; mCnt <= 0; end
              else mCnt <= mCnt + 1;
            end
          end else mCnt <= 0;
      endcase
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic step(input logic g, input logic t, input logic n, input logic tk);
    guardIn = g; tripIn = t; noiseIn = n; msTick = tk;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    guardIn = 0; tripIn = 0; noiseIn = 0; msTick = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();
    chk("R1 enable", tripEnable, 1'b0);
    chk("R1 defeated", defeated, 1'b0);

    // R3: noise restarts qualification
    step(1, 0, 0, 1); step(1, 0, 0, 1);
    step(1, 0, 1, 1);
    step(1, 0, 0, 1); step(1, 0, 0, 1);
    chk("R3 noise restart", tripEnable, 1'b0);
    step(1, 0, 0, 1);
    chk("R2 open after arm time", tripEnable, 1'b1);

    // R4: window expiry
    step(0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
    chk("R4 open inside window", tripEnable, 1'b1);
    step(0, 0, 0, 0);
    chk("R4 no close without tick", tripEnable, 1'b1);
    step(0, 0, 0, 1);
    chk("R4 closed at window end", tripEnable, 1'b0);

    // R8: trip ignored while closed
    step(0, 1, 0, 1);
    chk("R8 trip ignored blocked", defeated, 1'b0);
    chk("R8 enable stays low", tripEnable, 1'b0);

    // R6: reopening needs a full interval
    step(1, 0, 0, 1);
    step(1, 0, 0, 1); step(1, 0, 0, 1);
    chk("R6 still qualifying", tripEnable, 1'b0);
    step(1, 0, 0, 1);
    chk("R6 reopened", tripEnable, 1'b1);

    // R5: guard return discards the window count
    step(0, 0, 0, 1);
    step(0, 0, 0, 1); step(0, 0, 0, 1);
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
    chk("R5 fresh window", tripEnable, 1'b1);
    step(0, 0, 0, 1);
    chk("R5 window ends", tripEnable, 1'b0);
    step(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1);
    chk("R2 reopen", tripEnable, 1'b1);

    // R7/R9/R10/R11: defeat and re-arm
    step(0, 1, 0, 0);
    chk("R7 defeated", defeated, 1'b1);
    chk("R7 enable held", tripEnable, 1'b1);
    for (int i = 0; i < 500; i++) step(0, 0, 0, 1);
    chk("R9 enable held without guard", tripEnable, 1'b1);
    for (int i = 0; i < 50; i++) step(1, 0, 0, 1);
    step(0, 0, 0, 1);
    for (int i = 0; i < REARM_MS - 1; i++) step(1, 0, 0, 1);
    chk("R11 gap restarted rearm", defeated, 1'b1);
    step(1, 0, 0, 1);
    chk("R10 rearmed", defeated, 1'b0);
    chk("R10 enable kept", tripEnable, 1'b1);

    // R8 while qualifying; R2 zero setting
    armTimeMs = 16'd0;
    doReset();
    step(1, 1, 0, 0);
    chk("R8 trip ignored arming", defeated, 1'b0);
    step(1, 0, 0, 1);
    chk("R2 zero setting acts as one", tripEnable, 1'b1);

    // random phase against the expectation
    doReset();
    begin
      int runLeft = 0;
      logic g = 1'b0;
      for (int seg = 0; seg < 8; seg++) begin
        armTimeMs = CNT_W'($urandom_range(0, 6));
        windowMs  = CNT_W'($urandom_range(0, 8));
        for (int i = 0; i < 3000; i++) begin
          if (runLeft == 0) begin
            g = ~g;
            runLeft = g ? $urandom_range(1, 400) : $urandom_range(1, 40);
          end
          runLeft = runLeft - 1;
          step(g, ($urandom_range(0, 60) == 0), ($urandom_range(0, 40) == 0),
               ($urandom_range(0, 1) == 1));
          chk("R12 enable vs expected", tripEnable, expEnable(mState));
          chk("R12 defeated vs expected", defeated, mState == M_DEF);
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule